// File: doc/BRIEF.md
# Autocorrelation Heartbeat Period Estimator

This block takes one ECG lead as a stream of signed 16-bit samples and stores a fixed-length chunk of them in a local buffer. The default chunk is four seconds of signal at 250 Hz, i.e. 1000 samples. Once the buffer is full and a start request arrives, a single multiply-accumulate engine works through every candidate lag between a lower and an upper bound. For each lag it sums the products of the chunk with a copy of itself shifted by that lag. The lag whose sum is largest is reported as the heartbeat period, in samples. No peak detection is used for this step.

With the period known, the block scans the first period-long stretch of the chunk. It reports the position of the largest sample there as the R-peak index. A one-cycle done pulse marks new results. The buffer then empties and collects the next chunk.

The lag bounds are parameters in samples. The defaults, 75 and 500, stand for 0.3 s and 2.0 s at 250 Hz. The lower bound keeps the zero-lag maximum and its close neighbours out of the search.

Top module: `ahp_period_est`

## Requirements
- R1: While the buffer is filling, each cycle with `smp_valid_i` high stores `smp_data_i` at the next free position, until `N_SAMP` samples are held. Samples offered while the buffer is full, or while an analysis runs, are discarded. After `done_o` the buffer is empty again.
- R2: A `start_i` pulse while fewer than `N_SAMP` samples are held is ignored: no analysis begins and no `done_o` follows from it.
- R3: With samples x[i] read as two's-complement 16-bit values, `period_o` is the lag L in [`PER_MIN`, `PER_MAX`] that maximises S(L) = sum over i = 0 .. N_SAMP-1-L of x[i]*x[i+L]. Each S(L) is accumulated exactly in a 48-bit signed register, one product per clock.
- R4: When several lags give the same largest S(L), the smallest of them is reported.
- R5: `peak_idx_o` is the index j in [0, `period_o`-1] at which x[j] is largest (signed). On equal values the smallest index wins.
- R6: `done_o` is high for exactly one cycle per analysis. `period_o` and `peak_idx_o` change only in the cycle `done_o` is high and hold their values at all other times.
- R7: After synchronous reset, `done_o`, `period_o` and `peak_idx_o` are 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | SMP_W | Signed ECG sample |
| start_i | input | 1 | Request analysis of the held chunk |
| done_o | output | 1 | One-cycle pulse, results updated |
| period_o | output | LAG_W | Heartbeat period in samples |
| peak_idx_o | output | IDX_W | R-peak index within the chunk |

## Verification
Several properties are checked on every cycle. The results are held between done pulses, and done never lasts two cycles. A reported period always lies inside the lag range, and the peak index falls inside the period window. A start on a partly filled buffer never starts an analysis, and the fill count stays frozen at full while an analysis runs. The values themselves can only be shown by the bench scenarios, which compare against a reference search. These include the lag maximum, the tie rule for lags and for peak positions, and the discarding of samples that arrive while the buffer is full or busy.

// File: rtl/ahp_pkg.sv
package ahp_pkg;
  typedef enum logic [2:0] {
    ST_FILL,
    ST_CORR,
    ST_CDRAIN,
    ST_PEAK,
    ST_PDRAIN,
    ST_FINISH
  } ahp_state_e;
endpackage

// File: rtl/ahp_sample_mem.sv
module ahp_sample_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 1000,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_a <= store[addr_a];
    rd_b <= store[addr_b];
  end
endmodule

// File: rtl/ahp_mac_unit.sv
module ahp_mac_unit #(
  parameter int A_W   = 16,
  parameter int ACC_W = 48,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic             in_last,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [A_W-1:0]   op_a,
  input  logic [A_W-1:0]   op_b,
  output logic             out_v,
  output logic [ACC_W-1:0] out_sum,
  output logic [TAG_W-1:0] out_tag
);
  localparam int P_W = 2 * A_W;

  logic             p_v, p_last;
  logic [TAG_W-1:0] p_tag;
  logic [P_W-1:0]   prod;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] prod_ext;

  assign prod_ext = {{(ACC_W-P_W){prod[P_W-1]}}, prod};

  always_ff @(posedge clk) begin
    prod  <= $signed(op_a) * $signed(op_b);
    p_tag <= in_tag;
    if (rst) begin
      p_v     <= 1'b0;
      p_last  <= 1'b0;
      acc     <= '0;
      out_v   <= 1'b0;
      out_sum <= '0;
      out_tag <= '0;
    end else begin
      p_v    <= in_v;
      p_last <= in_last;
      out_v  <= 1'b0;
      if (p_v) begin
        if (p_last) begin
          out_sum <= acc + prod_ext;
          out_tag <= p_tag;
          out_v   <= 1'b1;
          acc     <= '0;
        end else begin
          acc <= acc + prod_ext;
        end
      end
    end
  end
endmodule

// File: rtl/ahp_argmax.sv
module ahp_argmax #(
  parameter int VAL_W = 48,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_v,
  input  logic [VAL_W-1:0] in_val,
  input  logic [TAG_W-1:0] in_tag,
  output logic [TAG_W-1:0] best_tag
);
  logic             have;
  logic [VAL_W-1:0] best_val;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have     <= 1'b0;
      best_val <= '0;
      best_tag <= '0;
    end else if (in_v && (!have || $signed(in_val) > $signed(best_val))) begin
      have     <= 1'b1;
      best_val <= in_val;
      best_tag <= in_tag;
    end
  end
endmodule

// File: rtl/ahp_period_est.sv
module ahp_period_est
  import ahp_pkg::*;
#(
  parameter int N_SAMP  = 1000,
  parameter int PER_MIN = 75,
  parameter int PER_MAX = 500,
  parameter int SMP_W   = 16,
  parameter int ACC_W   = 48,
  localparam int IDX_W  = $clog2(N_SAMP),
  localparam int LAG_W  = $clog2(PER_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             start_i,
  output logic             done_o,
  output logic [LAG_W-1:0] period_o,
  output logic [IDX_W-1:0] peak_idx_o
);
  localparam int CNT_W = $clog2(N_SAMP + 1);

  ahp_state_e       state;
  logic [CNT_W-1:0] fill_cnt;
  logic [IDX_W-1:0] idx_q;
  logic [LAG_W-1:0] lag_q;
  logic             full, busy, wr_en, go;
  logic             iss_last;
  logic [IDX_W-1:0] addr_b;
  logic [SMP_W-1:0] mem_a, mem_b;
  logic             rd_corr_v, rd_pk_v, rd_last;
  logic [LAG_W-1:0] rd_lag;
  logic [IDX_W-1:0] rd_idx;
  logic             mac_v;
  logic [ACC_W-1:0] mac_sum;
  logic [LAG_W-1:0] mac_tag;
  logic [LAG_W-1:0] best_lag;
  logic [IDX_W-1:0] best_idx;

  assign full  = (fill_cnt == CNT_W'(N_SAMP));
  assign busy  = (state != ST_FILL);
  assign wr_en = (state == ST_FILL) && smp_valid_i && !full;
  assign go    = (state == ST_FILL) && start_i && full;
  assign addr_b = idx_q + IDX_W'(lag_q);

  always_comb begin
    iss_last = 1'b0;
    if (state == ST_CORR)
      iss_last = (CNT_W'(idx_q) + CNT_W'(lag_q)) == CNT_W'(N_SAMP - 1);
    else if (state == ST_PEAK)
      iss_last = (CNT_W'(idx_q) + CNT_W'(1)) == CNT_W'(best_lag);
  end

  ahp_sample_mem #(.DW(SMP_W), .DEPTH(N_SAMP)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(fill_cnt[IDX_W-1:0]), .wr_data(smp_data_i),
    .addr_a(idx_q), .addr_b(addr_b), .rd_a(mem_a), .rd_b(mem_b)
  );

  // read-stage tags travel beside the one-cycle memory latency
  always_ff @(posedge clk) begin
    rd_lag <= lag_q;
    rd_idx <= idx_q;
    if (rst) begin
      rd_corr_v <= 1'b0;
      rd_pk_v   <= 1'b0;
      rd_last   <= 1'b0;
    end else begin
      rd_corr_v <= (state == ST_CORR);
      rd_pk_v   <= (state == ST_PEAK);
      rd_last   <= iss_last;
    end
  end

  ahp_mac_unit #(.A_W(SMP_W), .ACC_W(ACC_W), .TAG_W(LAG_W)) mac_i (
    .clk(clk), .rst(rst), .in_v(rd_corr_v), .in_last(rd_last), .in_tag(rd_lag),
    .op_a(mem_a), .op_b(mem_b), .out_v(mac_v), .out_sum(mac_sum), .out_tag(mac_tag)
  );

  ahp_argmax #(.VAL_W(ACC_W), .TAG_W(LAG_W)) lag_best_i (
    .clk(clk), .rst(rst), .clr(go), .in_v(mac_v), .in_val(mac_sum),
    .in_tag(mac_tag), .best_tag(best_lag)
  );

  ahp_argmax #(.VAL_W(SMP_W), .TAG_W(IDX_W)) peak_best_i (
    .clk(clk), .rst(rst), .clr(go), .in_v(rd_pk_v), .in_val(mem_a),
    .in_tag(rd_idx), .best_tag(best_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FILL;
      fill_cnt   <= '0;
      idx_q      <= '0;
      lag_q      <= '0;
      done_o     <= 1'b0;
      period_o   <= '0;
      peak_idx_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_FILL: begin
          if (wr_en) fill_cnt <= fill_cnt + 1'b1;
          if (go) begin
            state <= ST_CORR;
            idx_q <= '0;
            lag_q <= LAG_W'(PER_MIN);
          end
        end
        ST_CORR: begin
          if (iss_last) begin
            idx_q <= '0;
            if (lag_q == LAG_W'(PER_MAX)) state <= ST_CDRAIN;
            else lag_q <= lag_q + 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_CDRAIN: begin
          if (mac_v && mac_tag == LAG_W'(PER_MAX)) begin
            state <= ST_PEAK;
            idx_q <= '0;
          end
        end
        ST_PEAK: begin
          if (iss_last) state <= ST_PDRAIN;
          else idx_q <= idx_q + 1'b1;
        end
        ST_PDRAIN: begin
          if (rd_pk_v && rd_last) state <= ST_FINISH;
        end
        ST_FINISH: begin
          period_o   <= best_lag;
          peak_idx_o <= best_idx;
          done_o     <= 1'b1;
          fill_cnt   <= '0;
          state      <= ST_FILL;
        end
        default: state <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/ahp_period_est_chk.sv
module ahp_period_est_chk #(
  parameter int N_SAMP  = 1000,
  parameter int PER_MIN = 75,
  parameter int PER_MAX = 500,
  parameter int IDX_W   = 10,
  parameter int LAG_W   = 9,
  parameter int CNT_W   = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             done_o,
  input logic [LAG_W-1:0] period_o,
  input logic [IDX_W-1:0] peak_idx_o,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             busy
);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(period_o) && $stable(peak_idx_o)));

  a_r3_period_range: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (period_o >= LAG_W'(PER_MIN) && period_o <= LAG_W'(PER_MAX)));

  a_r5_peak_window: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (CNT_W'(peak_idx_o) < CNT_W'(period_o)));

  a_r2_start_needs_full: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i && fill_cnt != CNT_W'(N_SAMP)) |=> !busy);

  a_r1_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(N_SAMP));

  a_r1_frozen_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> fill_cnt == CNT_W'(N_SAMP));
endmodule

bind ahp_period_est ahp_period_est_chk #(
  .N_SAMP(N_SAMP), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
  .IDX_W(IDX_W), .LAG_W(LAG_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .period_o(period_o), .peak_idx_o(peak_idx_o), .fill_cnt(fill_cnt), .busy(busy)
);

// File: tb/ahp_period_est_tb_top.sv
module ahp_period_est_tb_top;
  localparam int N  = 200;
  localparam int LMIN = 15;
  localparam int LMAX = 100;
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(LMAX + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [15:0]   smp_data = '0;
  logic          start = 1'b0;
  logic          done;
  logic [LW-1:0] period;
  logic [IW-1:0] peak;

  int chunk [N];
  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_period = 0;

  always #2.5 clk = ~clk;

  ahp_period_est #(.N_SAMP(N), .PER_MIN(LMIN), .PER_MAX(LMAX)) dut_i (
    .clk(clk), .rst(rst), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .start_i(start), .done_o(done), .period_o(period), .peak_idx_o(peak)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_period();
    longint best = 0;
    int bl = LMIN;
    for (int l = LMIN; l <= LMAX; l++) begin
      longint s = 0;
      for (int i = 0; i + l < N; i++) s += longint'(chunk[i]) * longint'(chunk[i+l]);
      if (l == LMIN || s > best) begin best = s; bl = l; end
    end
    return bl;
  endfunction

  function automatic int ref_peak(input int p);
    int bi = 0;
    for (int j = 1; j < p; j++) if (chunk[j] > chunk[bi]) bi = j;
    return bi;
  endfunction

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  function automatic int noise(input int amp);
    return int'($urandom_range(0, 2*amp)) - amp;
  endfunction

  task automatic push(input int v);
    smp_valid = 1'b1;
    smp_data  = v[15:0];
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic fill(input int from, input int upto);
    for (int i = from; i < upto; i++) push(chunk[i]);
  endtask

  // start, wait for done, compare; noisy drives stray samples during the run
  task automatic run(input string tag, input bit noisy);
    int ep, ek;
    bit seen = 1'b0;
    ep = ref_period();
    ek = ref_peak(ep);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20000 && !seen; t++) begin
      if (noisy) begin smp_valid = 1'b1; smp_data = 16'($urandom); end
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    smp_valid = 1'b0;
    chk(seen, {tag, " R6 done seen"}, seen, 1);
    chk(int'(period) == ep, {tag, " R3 period"}, period, ep);
    chk(int'(peak) == ek, {tag, " R5 peak index"}, peak, ek);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done one cycle"}, done, 0);
    last_period = ep;
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(period == '0, "R7 reset period", period, 0);
    chk(peak == '0, "R7 reset peak", peak, 0);

    // R2: early start ignored, then R1: extra samples after full discarded
    for (int i = 0; i < N; i++) chunk[i] = rnd16();
    fill(0, 50);
    start = 1'b1; @(negedge clk); start = 1'b0;
    begin
      bit any = 1'b0;
      for (int t = 0; t < 60; t++) begin @(negedge clk); if (done) any = 1'b1; end
      chk(!any, "R2 start before full ignored", any, 0);
    end
    fill(50, N);
    for (int k = 0; k < 10; k++) push(rnd16());
    run("S1 random R1", 1'b0);

    // spike train period 40, stray samples while busy (R1), hold check (R6)
    for (int i = 0; i < N; i++) chunk[i] = ((i % 40) == 7) ? 9000 : noise(30);
    fill(0, N);
    chk(int'(period) == last_period, "R6 period held before start", period, last_period);
    run("S2 spikes40 busy R1", 1'b1);

    // all-zero chunk: every lag ties -> smallest lag, peak index 0 (R4, R5)
    for (int i = 0; i < N; i++) chunk[i] = 0;
    fill(0, N);
    run("S3 zeros R4", 1'b0);
    chk(int'(period) == LMIN, "R4 zero chunk lag min", period, LMIN);
    chk(peak == '0, "R5 tie earliest", peak, 0);

    // three pulses: lags 40, 50, 90 tie -> 40 (R4)
    for (int i = 0; i < N; i++) chunk[i] = 0;
    chunk[0] = 3000; chunk[40] = 3000; chunk[90] = 3000;
    fill(0, N);
    run("S4 tie R4", 1'b0);
    chk(int'(period) == 40, "R4 nonzero tie smallest lag", period, 40);

    // period at the upper bound with negative baseline
    for (int i = 0; i < N; i++) chunk[i] = ((i % LMAX) == 12) ? 20000 : -3 + noise(2);
    fill(0, N);
    run("S5 max lag R3", 1'b0);

    // constant chunk: equal samples, earliest index (R5)
    for (int i = 0; i < N; i++) chunk[i] = 5;
    fill(0, N);
    run("S6 const R5", 1'b0);

    // random mixes: beat with jitter-free period and noise
    for (int r = 0; r < 2; r++) begin
      int p = int'($urandom_range(LMIN + 5, LMAX - 5));
      int off = int'($urandom_range(0, p - 1));
      for (int i = 0; i < N; i++)
        chunk[i] = (((i + p - off) % p) == 0) ? 15000 + noise(500) : noise(800);
      fill(0, N);
      run("S7 random beat R3", 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule